// File: doc/BRIEF.md
# Lockable Boot-Vector System Control Registers

This block is a small memory-mapped control register file for a subsystem with one processor core. Its main register holds the base address of the core's initial secure vector table. That register has a lock flag in its lowest bit. Once software writes the flag as 1, the register refuses every later write until the next system reset. The exported vector keeps only the table-aligned upper bits of the stored word.

The same register window also contains:
- a 32-bit general retention register that firmware can use as scratch storage across a warm restart;
- a core-wait control flag;
- an NMI-enable flag;
- a software reset request bit that produces a single-cycle request pulse.

The window has an offset where a second core's vector register would sit in a multi-core variant. Here that offset answers with a bus error, as does every other unmapped offset.

The bus is a simple single-cycle 32-bit register port. The read data and the error response are combinational on the cycle the access is presented. Writes take effect at the next clock edge.

Top module: `bootvec_sysctl`

## Requirements
- R1: After a synchronous reset, the vector register holds the parameter `RST_VTOR` with bit 0 (lock) cleared. `init_vtor` shows that value with bits 6:0 zero. `cpu_wait` equals `CPUWAIT_RST` (default 0). `nmi_enable`, the retention register, `swreset_req` and `locked_write_err` are 0.
- R2: While the lock flag is 0, a write to offset 0x110 stores all 32 bits. A read of 0x110 returns the full stored word, including bit 0 and bits 6:1 as written.
- R3: `init_vtor` equals the stored vector word with bits 31:7 kept and bits 6:0 forced to 0.
- R4: While the stored bit 0 of offset 0x110 is 1, writes to 0x110 leave the stored word and `init_vtor` unchanged and give no bus error. Each rejected write makes `locked_write_err` high for exactly the one cycle after the write's clock edge.
- R5: The lock decision uses the value stored before the write. A write whose bit 0 is 1 to an unlocked register is accepted in full, and the next write is rejected.
- R6: Writing 1 to bit 9 of offset 0x108 makes `swreset_req` high for the single cycle after that clock edge. Reads of 0x108 return 0.
- R7: Offset 0x10C is a 32-bit read/write retention register.
- R8: Bit 0 of offset 0x118 drives `cpu_wait` and bit 0 of offset 0x11C drives `nmi_enable`. Reads of these offsets return the flag in bit 0 and zeros above it.
- R9: An access to offset 0x114, the absent second-core vector register, returns read data 0 with `bus_err` high and changes no state.
- R10: An access to any offset other than 0x108, 0x10C, 0x110, 0x118 and 0x11C returns read data 0 with `bus_err` high and changes no state.
- R11: `bus_err` is high only while `bus_sel` is high and the offset is unmapped. It is never high for the five mapped offsets, including a locked write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Error response for an unmapped offset |
| init_vtor | output | 32 | Initial vector table base, bits 6:0 zero |
| swreset_req | output | 1 | Single-cycle software reset request |
| cpu_wait | output | 1 | Core wait control |
| nmi_enable | output | 1 | NMI enable |
| locked_write_err | output | 1 | One-cycle pulse after a rejected write |

## Verification
The software reset pulse and the rejection of a write to the locked vector register can both be in flight in the same cycle. The bench provokes this by writing the reset request bit and then presenting a vector write on the very next cycle, while `swreset_req` is still high.

It then judges three things:
- the reset pulse still lasts exactly one cycle;
- `locked_write_err` rises one cycle later without a bus error;
- the stored vector and `init_vtor` are unchanged.

A write that sets the lock bit, followed by further writes, shows that the decision is made on the pre-write value.

// File: rtl/bootvec_sysctl_pkg.sv
package bootvec_sysctl_pkg;

    localparam int unsigned WORD_W = 32;

    // Byte offsets of the register window
    localparam logic [11:0] OFS_SWRST   = 12'h108;
    localparam logic [11:0] OFS_GRET    = 12'h10C;
    localparam logic [11:0] OFS_VTOR0   = 12'h110;
    localparam logic [11:0] OFS_VTOR1   = 12'h114;
    localparam logic [11:0] OFS_CPUWAIT = 12'h118;
    localparam logic [11:0] OFS_NMI     = 12'h11C;

    localparam int unsigned SWRST_BIT = 9;
    localparam int unsigned LOCK_BIT  = 0;
    localparam int unsigned VTOR_LSB  = 7;

    localparam int unsigned N_FLAGS = 2;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_SWRST   = 3'd1,
        SEL_GRET    = 3'd2,
        SEL_VTOR0   = 3'd3,
        SEL_HOLE    = 3'd4,
        SEL_CPUWAIT = 3'd5,
        SEL_NMI     = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              we;
        reg_sel_e          sel;
        logic [WORD_W-1:0] wdata;
    } reg_access_t;

    function automatic logic [WORD_W-1:0] vtor_base(input logic [WORD_W-1:0] raw);
        logic [WORD_W-1:0] mask;
        mask = {{(WORD_W-VTOR_LSB){1'b1}}, {VTOR_LSB{1'b0}}};
        return raw & mask;
    endfunction

    function automatic logic [WORD_W-1:0] flag_word(input logic b);
        return {{(WORD_W-1){1'b0}}, b};
    endfunction

    function automatic logic sel_is_bad(input reg_sel_e s);
        return (s == SEL_NONE) || (s == SEL_HOLE);
    endfunction

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import bootvec_sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              bad
);

    logic [31:0] addr_ext;

    assign addr_ext = 32'(addr);

    always_comb begin
        sel = SEL_NONE;
        if      (addr_ext == 32'(OFS_SWRST))   sel = SEL_SWRST;
        else if (addr_ext == 32'(OFS_GRET))    sel = SEL_GRET;
        else if (addr_ext == 32'(OFS_VTOR0))   sel = SEL_VTOR0;
        else if (addr_ext == 32'(OFS_VTOR1))   sel = SEL_HOLE;
        else if (addr_ext == 32'(OFS_CPUWAIT)) sel = SEL_CPUWAIT;
        else if (addr_ext == 32'(OFS_NMI))     sel = SEL_NMI;
    end

    assign bad = sel_is_bad(sel);

endmodule

// File: rtl/sysctl_vtor_reg.sv
module sysctl_vtor_reg
    import bootvec_sysctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VTOR = 32'h1000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_access_t       acc,
    output logic [WORD_W-1:0] stored_q,
    output logic [WORD_W-1:0] init_vtor,
    output logic              locked_write_err
);

    localparam logic [WORD_W-1:0] RST_WORD = RST_VTOR & ~(WORD_W'(1) << LOCK_BIT);

    logic wr_hit;
    logic locked;

    assign wr_hit = acc.valid && acc.we && (acc.sel == SEL_VTOR0);
    assign locked = stored_q[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q         <= RST_WORD;
            locked_write_err <= 1'b0;
        end else begin
            locked_write_err <= wr_hit && locked;
            if (wr_hit && !locked) begin
                stored_q <= acc.wdata;
            end
        end
    end

    assign init_vtor = vtor_base(stored_q);

endmodule

// File: rtl/sysctl_ctrl_regs.sv
module sysctl_ctrl_regs
    import bootvec_sysctl_pkg::*;
#(
    parameter logic CPUWAIT_RST = 1'b0,
    parameter logic NMI_RST     = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  reg_access_t         acc,
    output logic [WORD_W-1:0]   gret_q,
    output logic [N_FLAGS-1:0]  flag_q,
    output logic                swreset_req
);

    logic wr;

    assign wr = acc.valid && acc.we;

    always_ff @(posedge clk) begin
        if (rst) begin
            gret_q      <= '0;
            swreset_req <= 1'b0;
        end else begin
            swreset_req <= wr && (acc.sel == SEL_SWRST) && acc.wdata[SWRST_BIT];
            if (wr && (acc.sel == SEL_GRET)) begin
                gret_q <= acc.wdata;
            end
        end
    end

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        localparam reg_sel_e FSEL = (g == 0) ? SEL_CPUWAIT : SEL_NMI;
        localparam logic     FRST = (g == 0) ? CPUWAIT_RST : NMI_RST;
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[g] <= FRST;
            end else if (wr && (acc.sel == FSEL)) begin
                flag_q[g] <= acc.wdata[0];
            end
        end
    end

endmodule

// File: rtl/bootvec_sysctl.sv
module bootvec_sysctl
    import bootvec_sysctl_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 12,
    parameter logic [31:0]       RST_VTOR    = 32'h1000_0000,
    parameter logic              CPUWAIT_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [31:0]       init_vtor,
    output logic              swreset_req,
    output logic              cpu_wait,
    output logic              nmi_enable,
    output logic              locked_write_err
);

    reg_sel_e           dec_sel;
    logic               dec_bad;
    reg_access_t        acc;
    logic [WORD_W-1:0]  vtor_q;
    logic [WORD_W-1:0]  gret_q;
    logic [N_FLAGS-1:0] flag_q;

    sysctl_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (dec_sel),
        .bad  (dec_bad)
    );

    assign acc.valid = bus_sel;
    assign acc.we    = bus_we;
    assign acc.sel   = dec_sel;
    assign acc.wdata = bus_wdata;

    sysctl_vtor_reg #(.RST_VTOR(RST_VTOR)) u_vtor (
        .clk              (clk),
        .rst              (rst),
        .acc              (acc),
        .stored_q         (vtor_q),
        .init_vtor        (init_vtor),
        .locked_write_err (locked_write_err)
    );

    sysctl_ctrl_regs #(.CPUWAIT_RST(CPUWAIT_RST), .NMI_RST(1'b0)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .gret_q      (gret_q),
        .flag_q      (flag_q),
        .swreset_req (swreset_req)
    );

    assign cpu_wait   = flag_q[0];
    assign nmi_enable = flag_q[1];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (dec_sel)
                SEL_GRET:    bus_rdata = gret_q;
                SEL_VTOR0:   bus_rdata = vtor_q;
                SEL_CPUWAIT: bus_rdata = flag_word(flag_q[0]);
                SEL_NMI:     bus_rdata = flag_word(flag_q[1]);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign bus_err = bus_sel && dec_bad;

endmodule

// File: rtl/bootvec_sysctl_chk.sv
module bootvec_sysctl_chk
    import bootvec_sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic [31:0]       init_vtor,
    input logic              swreset_req,
    input logic              locked_write_err
);

    logic hit_vtor0;
    logic hit_vtor1;
    logic hit_swrst;

    assign hit_vtor0 = (32'(bus_addr) == 32'(OFS_VTOR0));
    assign hit_vtor1 = (32'(bus_addr) == 32'(OFS_VTOR1));
    assign hit_swrst = (32'(bus_addr) == 32'(OFS_SWRST));

    AST_SWRST_CAUSE: assert property (@(posedge clk) disable iff (rst)
        swreset_req |-> $past(bus_sel && bus_we && hit_swrst && bus_wdata[SWRST_BIT])); // R6

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        locked_write_err |-> $stable(init_vtor)); // R4

    AST_LOCKERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        locked_write_err |-> $past(bus_sel && bus_we && hit_vtor0)); // R4

    AST_VTOR_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && hit_vtor0) |-> !bus_err); // R11

    AST_HOLE_ERR: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && hit_vtor1) |-> (bus_err && bus_rdata == 32'h0)); // R9

    AST_ERR_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> !bus_err); // R11

endmodule

bind bootvec_sysctl bootvec_sysctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_sel          (bus_sel),
    .bus_we           (bus_we),
    .bus_addr         (bus_addr),
    .bus_wdata        (bus_wdata),
    .bus_rdata        (bus_rdata),
    .bus_err          (bus_err),
    .init_vtor        (init_vtor),
    .swreset_req      (swreset_req),
    .locked_write_err (locked_write_err)
);

// File: tb/test_bootvec_sysctl.sv
module test_bootvec_sysctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] init_vtor;
    logic        swreset_req;
    logic        cpu_wait;
    logic        nmi_enable;
    logic        locked_write_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bootvec_sysctl #(.ADDR_W(12), .RST_VTOR(32'h1000_0000), .CPUWAIT_RST(1'b0)) i_bootvec_sysctl (
        .clk              (clk),
        .rst              (rst),
        .bus_sel          (bus_sel),
        .bus_we           (bus_we),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_rdata        (bus_rdata),
        .bus_err          (bus_err),
        .init_vtor        (init_vtor),
        .swreset_req      (swreset_req),
        .cpu_wait         (cpu_wait),
        .nmi_enable       (nmi_enable),
        .locked_write_err (locked_write_err)
    );

    // {we, addr, wdata, expected rdata (reads only), expected err}
    localparam int NV = 19;
    localparam logic [77:0] VEC [NV] = '{
        {1'b0, 12'h110, 32'h0,         32'h1000_0000, 1'b0}, // R1
        {1'b0, 12'h118, 32'h0,         32'h0,         1'b0}, // R1
        {1'b0, 12'h11C, 32'h0,         32'h0,         1'b0}, // R1
        {1'b0, 12'h10C, 32'h0,         32'h0,         1'b0}, // R1
        {1'b1, 12'h10C, 32'hCAFE_F00D, 32'h0,         1'b0}, // R7
        {1'b0, 12'h10C, 32'h0,         32'hCAFE_F00D, 1'b0}, // R7
        {1'b1, 12'h118, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R8
        {1'b0, 12'h118, 32'h0,         32'h1,         1'b0}, // R8
        {1'b1, 12'h11C, 32'h0000_0003, 32'h0,         1'b0}, // R8
        {1'b0, 12'h11C, 32'h0,         32'h1,         1'b0}, // R8
        {1'b1, 12'h114, 32'h0000_1234, 32'h0,         1'b1}, // R9
        {1'b0, 12'h114, 32'h0,         32'h0,         1'b1}, // R9
        {1'b0, 12'h120, 32'h0,         32'h0,         1'b1}, // R10
        {1'b1, 12'h100, 32'hFFFF_FFFF, 32'h0,         1'b1}, // R10
        {1'b0, 12'h10C, 32'h0,         32'hCAFE_F00D, 1'b0}, // R10 no change
        {1'b0, 12'h110, 32'h0,         32'h1000_0000, 1'b0}, // R9 no change
        {1'b1, 12'h110, 32'h2000_00FE, 32'h0,         1'b0}, // R2
        {1'b0, 12'h110, 32'h0,         32'h2000_00FE, 1'b0}, // R2
        {1'b0, 12'h108, 32'h0,         32'h0,         1'b0}  // R6
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic op(input logic we, input logic [11:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        bus_sel = 1'b1;
        bus_we = we;
        bus_addr = a;
        bus_wdata = d;
        #4;
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_we = 1'b0;
        #4;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        op(1'b0, a, 32'h0);
        check(bus_rdata == exp && !bus_err, req, bus_rdata, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #4;
        // R1 reset outputs
        check(init_vtor == 32'h1000_0000, "R1", init_vtor, 32'h1000_0000);
        check({swreset_req, cpu_wait, nmi_enable, locked_write_err} == 4'b0, "R1",
              32'({swreset_req, cpu_wait, nmi_enable, locked_write_err}), 32'h0);

        for (int i = 0; i < NV; i++) begin
            op(VEC[i][77], VEC[i][76:65], VEC[i][64:33]);
            check(bus_err == VEC[i][0], "R11 err", 32'(bus_err), 32'(VEC[i][0]));
            if (!VEC[i][77])
                check(bus_rdata == VEC[i][32:1], "R2/R7/R8/R9/R10 rdata", bus_rdata, VEC[i][32:1]);
        end
        idle();
        check(cpu_wait && nmi_enable, "R8", 32'({cpu_wait, nmi_enable}), 32'h3);
        // R3 exported vector
        check(init_vtor == 32'h2000_0080, "R3", init_vtor, 32'h2000_0080);

        // R6 software reset pulse
        op(1'b1, 12'h108, 32'h0000_0200);
        check(!swreset_req, "R6", 32'(swreset_req), 32'h0);
        idle();
        check(swreset_req, "R6", 32'(swreset_req), 32'h1);
        idle();
        check(!swreset_req, "R6", 32'(swreset_req), 32'h0);

        // R5 lock-setting write accepted in full
        op(1'b1, 12'h110, 32'h3000_0041);
        idle();
        check(init_vtor == 32'h3000_0000, "R5", init_vtor, 32'h3000_0000);
        rd(12'h110, 32'h3000_0041, "R5");

        // R4 locked write overlapping the reset pulse
        op(1'b1, 12'h108, 32'h0000_0200);
        op(1'b1, 12'h110, 32'h4000_0000);
        check(swreset_req, "R6 overlap", 32'(swreset_req), 32'h1);
        check(!bus_err, "R4 no err", 32'(bus_err), 32'h0);
        idle();
        check(locked_write_err, "R4 pulse", 32'(locked_write_err), 32'h1);
        check(!swreset_req, "R6 overlap end", 32'(swreset_req), 32'h0);
        idle();
        check(!locked_write_err, "R4 pulse end", 32'(locked_write_err), 32'h0);
        check(init_vtor == 32'h3000_0000, "R4", init_vtor, 32'h3000_0000);
        rd(12'h110, 32'h3000_0041, "R4");
        op(1'b1, 12'h110, 32'h0);
        idle();
        rd(12'h110, 32'h3000_0041, "R4 unlock attempt");

        // R1 reset clears lock
        @(posedge clk);
        #1 rst = 1'b1;
        bus_sel = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        #4;
        check(init_vtor == 32'h1000_0000, "R1", init_vtor, 32'h1000_0000);
        check({cpu_wait, nmi_enable} == 2'b0, "R1", 32'({cpu_wait, nmi_enable}), 32'h0);
        rd(12'h110, 32'h1000_0000, "R1");
        rd(12'h10C, 32'h0, "R1");
        op(1'b1, 12'h110, 32'h5000_0000);
        rd(12'h110, 32'h5000_0000, "R2 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule